// File: doc/BRIEF.md
# USB Bulk-In Double-Buffered Transmit FIFO

This block buffers outgoing data for one bulk-in endpoint in two 64-byte banks. At any moment one bank belongs to the CPU, which fills it one byte at a time through an 8-bit write port. The block keeps the write position itself, so the CPU only supplies bytes in order. The other bank belongs to the serial engine, which reads a committed packet out of it in response to IN tokens.

A CPU bank is committed in one of two ways. It is committed when it is full, or when the CPU raises the end-of-data flag. The flag allows short packets, and a zero-length packet when the bank is still empty. The banks trade places only when the engine side holds no pending packet and the CPU side is committed.

On an IN token the block answers one cycle later. It starts a transfer when sending is enabled and a packet is pending, and answers NAK in every other case. A failed transfer keeps the same bank for a resend. An acknowledged transfer frees the engine bank, sets a sticky done status bit and pulses either an interrupt request or a DMA request.

Top module: `usb_bulkin_pingpong`

## Requirements
- R1: After reset, `data_exists`, `done_stat`, `irq`, `dma_req`, `tx_start` and `tx_nak` are 0 and `tx_len` is 0.
- R2: `cpu_rdata` always reads as 8'h00.
- R3: Bytes written with `cpu_wr` are stored at consecutive positions of the CPU bank. From the first byte of a packet, `eng_rdata` shows them in write order, and each `eng_rd` advances to the next byte.
- R4: When no packet is pending on the engine side and the CPU bank holds 64 bytes, the banks swap at the next clock edge. `data_exists` then reads 1 and `tx_len` reads 64.
- R5: Pulsing `cpu_dend` after writing 1 to 63 bytes commits a short packet. After the swap, `tx_len` equals the number of bytes written.
- R6: Pulsing `cpu_dend` while the CPU bank is empty commits a zero-length packet. `data_exists` reads 1 and `tx_len` reads 0.
- R7: While a packet is pending on the engine side, a committed CPU bank waits. Writes to a committed CPU bank, whether full or flagged, are dropped.
- R8: The cycle after `in_token`, `tx_start` pulses if `nak_off` is 1 and a packet is pending. Otherwise `tx_nak` pulses.
- R9: `tx_ok` with a pending packet clears `data_exists` and sets `done_stat` at the next edge. `done_clr` clears `done_stat`.
- R10: That acknowledgement pulses `irq` for one cycle when `req_sel` is 0, and `dma_req` when `req_sel` is 1. The other request stays 0.
- R11: `tx_fail` keeps the pending packet and its length. The next token resends it from its first byte.
- R12: The end-of-data flag is cleared by the swap that consumes it, so the next empty CPU bank is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read value of the data port, always 0 |
| cpu_dend | input | 1 | Pulse to set the end-of-data flag |
| nak_off | input | 1 | 1 allows packets to be sent on IN tokens |
| in_token | input | 1 | IN token addressed to this endpoint |
| tx_start | output | 1 | Pulse: a packet of `tx_len` bytes starts |
| tx_nak | output | 1 | Pulse: token answered with NAK |
| tx_len | output | 7 | Length of the pending packet |
| eng_rd | input | 1 | Engine byte read strobe |
| eng_rdata | output | 8 | Current engine byte |
| tx_ok | input | 1 | Transfer acknowledged by host |
| tx_fail | input | 1 | Transfer not acknowledged |
| data_exists | output | 1 | A committed packet is pending on the engine side |
| done_stat | output | 1 | Sticky transmit-done status |
| done_clr | input | 1 | Clears `done_stat` |
| req_sel | input | 1 | 0 selects interrupt, 1 selects DMA request |
| irq | output | 1 | Interrupt request pulse |
| dma_req | output | 1 | DMA request pulse |

## Verification
A wrong bank-select bit shows within one packet. Either `eng_rdata` returns bytes from the bank the CPU is filling, or it returns bytes from the previous packet. A wrong CPU byte count or a stuck end-of-data flag shows as a wrong `tx_len`, or as a `data_exists` rise at the swap edge with no cause. Lost pending state shows as `tx_nak` on the very next token.

// File: rtl/usb_bulkin_pingpong.sv
module usb_bulkin_pingpong #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cpu_dend,
  input  logic          nak_off,
  input  logic          in_token,
  output logic          tx_start,
  output logic          tx_nak,
  output logic [$clog2(DEPTH+1)-1:0] tx_len,
  input  logic          eng_rd,
  output logic [DW-1:0] eng_rdata,
  input  logic          tx_ok,
  input  logic          tx_fail,
  output logic          data_exists,
  output logic          done_stat,
  input  logic          done_clr,
  input  logic          req_sel,
  output logic          irq,
  output logic          dma_req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [2][DEPTH];
  logic          sel, eng_valid, dend_q;
  logic [CW-1:0] cpu_cnt, eng_cnt, rd_ptr;

  wire cpu_commit = (cpu_cnt == CW'(DEPTH)) || dend_q;
  wire swap       = !eng_valid && cpu_commit;
  wire wr_ok      = cpu_wr && !cpu_commit;
  wire ok_hit     = tx_ok && eng_valid;
  wire send       = in_token && nak_off && eng_valid;

  assign cpu_rdata   = '0;
  assign data_exists = eng_valid;
  assign tx_len      = eng_cnt;
  assign eng_rdata   = mem[!sel][rd_ptr[AW-1:0]];

  always_ff @(posedge clk)
    if (wr_ok) mem[sel][cpu_cnt[AW-1:0]] <= cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= 1'b0; eng_valid <= 1'b0; dend_q <= 1'b0;
      cpu_cnt <= '0; eng_cnt <= '0; rd_ptr <= '0;
      tx_start <= 1'b0; tx_nak <= 1'b0;
      done_stat <= 1'b0; irq <= 1'b0; dma_req <= 1'b0;
    end else begin
      if (swap) begin
        sel       <= ~sel;
        eng_valid <= 1'b1;
        eng_cnt   <= cpu_cnt;
        cpu_cnt   <= '0;
        dend_q    <= 1'b0;
      end else begin
        if (wr_ok)    cpu_cnt <= cpu_cnt + 1'b1;
        if (cpu_dend) dend_q  <= 1'b1;
      end
      if (ok_hit) begin
        eng_valid <= 1'b0;
        eng_cnt   <= '0;
      end
      if (send || tx_fail || ok_hit)       rd_ptr <= '0;
      else if (eng_rd && rd_ptr < eng_cnt) rd_ptr <= rd_ptr + 1'b1;
      tx_start <= send;
      tx_nak   <= in_token && !send;
      if (ok_hit)        done_stat <= 1'b1;
      else if (done_clr) done_stat <= 1'b0;
      irq     <= ok_hit && !req_sel;
      dma_req <= ok_hit && req_sel;
    end
  end
endmodule

// File: rtl/usb_bulkin_pingpong_chk.sv
module usb_bulkin_pingpong_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cpu_cnt,
  input logic          dend_q,
  input logic          data_exists,
  input logic [CW-1:0] tx_len,
  input logic          in_token,
  input logic          nak_off,
  input logic          tx_start,
  input logic          tx_nak,
  input logic          tx_ok,
  input logic          tx_fail,
  input logic          req_sel,
  input logic          irq,
  input logic          dma_req,
  input logic          done_stat
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cpu_cnt <= CW'(DEPTH)); // R7
  AST_SWAP_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_exists) |-> (tx_len == $past(cpu_cnt)) && ($past(cpu_cnt) == CW'(DEPTH) || $past(dend_q))); // R4
  AST_FLAG_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n) $rose(data_exists) |-> !dend_q); // R12
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(in_token && nak_off && data_exists)); // R8
  AST_NAK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak |-> $past(in_token && !(nak_off && data_exists))); // R8
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fail && !tx_ok && data_exists) |=> data_exists && $stable(tx_len)); // R11
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && data_exists) |=> done_stat && !data_exists); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tx_ok && data_exists && !req_sel)); // R10
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(tx_ok && data_exists && req_sel)); // R10
endmodule

bind usb_bulkin_pingpong usb_bulkin_pingpong_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_cnt(cpu_cnt), .dend_q(dend_q),
  .data_exists(data_exists), .tx_len(tx_len), .in_token(in_token),
  .nak_off(nak_off), .tx_start(tx_start), .tx_nak(tx_nak), .tx_ok(tx_ok),
  .tx_fail(tx_fail), .req_sel(req_sel), .irq(irq), .dma_req(dma_req),
  .done_stat(done_stat)
);

// File: tb/usb_bulkin_pingpong_bench.sv
module usb_bulkin_pingpong_bench;
  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_dend = 0, nak_off = 1, in_token = 0, eng_rd = 0;
  logic tx_ok = 0, tx_fail = 0, done_clr = 0, req_sel = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata, eng_rdata;
  logic [6:0] tx_len;
  logic tx_start, tx_nak, data_exists, done_stat, irq, dma_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  usb_bulkin_pingpong u_usb_bulkin_pingpong (.*);

  // {base, dma, fail, len}
  localparam logic [16:0] VEC [0:5] = '{
    {8'h10, 1'b0, 1'b0, 7'd64}, {8'h30, 1'b0, 1'b0, 7'd5},
    {8'h50, 1'b1, 1'b0, 7'd0},  {8'h70, 1'b0, 1'b1, 7'd1},
    {8'h90, 1'b1, 1'b0, 7'd63}, {8'hB0, 1'b0, 1'b1, 7'd64}};

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk) begin cpu_wr = 1; cpu_wdata = b; end
    @(negedge clk) cpu_wr = 0;
  endtask

  task automatic pulse_dend();
    @(negedge clk) cpu_dend = 1;
    @(negedge clk) cpu_dend = 0;
  endtask

  task automatic token(input logic exp_start, string r);
    @(negedge clk) in_token = 1;
    @(negedge clk) in_token = 0;
    check({r, " tx_start"}, tx_start, exp_start);
    check({r, " tx_nak"}, tx_nak, !exp_start);
  endtask

  task automatic read_pkt(input int n, input logic [7:0] base, string r);
    for (int i = 0; i < n; i++) begin
      check(r, eng_rdata, 8'(base + i));
      eng_rd = 1;
      @(negedge clk);
    end
    eng_rd = 0;
  endtask

  task automatic ack(input logic dma, string r);
    req_sel = dma;
    @(negedge clk) tx_ok = 1;
    @(negedge clk) tx_ok = 0;
    check({r, " irq"}, irq, !dma);
    check({r, " dma_req"}, dma_req, dma);
    check("R9 done_stat", done_stat, 1);
    check("R9 data_exists cleared", data_exists, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 data_exists", data_exists, 0);
    check("R1 done_stat", done_stat, 0);
    check("R1 irq|dma", {irq, dma_req}, 0);
    check("R1 tx_start|tx_nak", {tx_start, tx_nak}, 0);
    check("R1 tx_len", tx_len, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 cpu_rdata", cpu_rdata, 0);
    token(0, "R8 empty");

    for (int v = 0; v < 6; v++) begin
      automatic int n = int'(VEC[v][6:0]);
      automatic logic [7:0] base = VEC[v][16:9];
      for (int i = 0; i < n; i++) wr(8'(base + i));
      check("R2 cpu_rdata after writes", cpu_rdata, 0);
      if (n < 64) pulse_dend();
      @(negedge clk);
      check(n == 64 ? "R4 full swap" : (n == 0 ? "R6 null" : "R5 short"), data_exists, 1);
      check(n == 64 ? "R4 tx_len" : (n == 0 ? "R6 tx_len" : "R5 tx_len"), tx_len, n);
      nak_off = 0;
      token(0, "R8 nak_off=0");
      nak_off = 1;
      token(1, "R8 send");
      read_pkt(n, base, "R3 data");
      if (VEC[v][7]) begin
        @(negedge clk) tx_fail = 1;
        @(negedge clk) tx_fail = 0;
        check("R11 kept", data_exists, 1);
        check("R11 len", tx_len, n);
        token(1, "R11 resend");
        read_pkt(n, base, "R11 data");
      end
      ack(VEC[v][8], "R10");
      @(negedge clk) done_clr = 1;
      @(negedge clk) done_clr = 0;
      check("R9 done_clr", done_stat, 0);
      repeat (3) @(negedge clk);
      check("R12 no stale commit", data_exists, 0);
    end

    for (int i = 0; i < 64; i++) wr(8'(8'h40 + i));
    @(negedge clk);
    check("R4 A pending", data_exists, 1);
    for (int i = 0; i < 64; i++) wr(8'(8'h80 + i));
    wr(8'hEE);
    @(negedge clk);
    check("R7 A kept", tx_len, 64);
    token(1, "R7 A");
    read_pkt(2, 8'h40, "R7 A data");
    ack(0, "R10 A");
    @(negedge clk);
    check("R7 B swapped", data_exists, 1);
    for (int i = 0; i < 3; i++) wr(8'(8'hC0 + i));
    pulse_dend();
    wr(8'hEE);
    token(1, "R7 B");
    read_pkt(64, 8'h80, "R7 B data");
    ack(1, "R10 B");
    @(negedge clk);
    check("R7 C swapped", data_exists, 1);
    check("R7 C len", tx_len, 3);
    token(1, "R7 C");
    read_pkt(3, 8'hC0, "R7 C data");
    ack(0, "R10 C");
    repeat (3) @(negedge clk);
    check("R12 idle", data_exists, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule